// File: doc/BRIEF.md
# Dual-Bank Serial Programming Interface

This block is the three-wire programming front end of a frequency-synthesizer controller. A slow serial clock, a data line and an active-low load window arrive from outside. The block samples all three in the system clock domain. Each rising edge of the serial clock that falls inside the load window shifts one bit into the current target, most significant bit first. The target is one of two shift registers: a wide main word, or a narrow enhancement word. A select input picks which one receives the bits.

When the load window closes, the main word is copied into a shadow word. A live frame-select input then decides which of the two drives the counter-programming outputs. This lets software stage a new setting and then switch to it in a single step.

The enhancement word reaches its outputs only while an active-low enhancement-mode input is asserted. In that same mode, a serial echo output shows the leading bit of the register that was shifted last.

Top module: `dual_bank_serial_loader`

## Requirements
- R1: On each synchronized rising edge of `ser_clk_i`, while `bank_sel_i` is 0, the main word shifts left by one and takes the synchronized `ser_dat_i` as its new LSB. After 20 such edges, the first bit sent is bit 19.
- R2: While `bank_sel_i` is 1, each such edge shifts the 8-bit enhancement word in the same way, and the main word does not change.
- R3: Edges of `ser_clk_i` seen while `ser_ld_n_i` is high change neither register.
- R4: A rising edge of `ser_ld_n_i` copies the main word into the shadow word. The shadow word changes at no other time.
- R5: One clock after it is sampled, `frame_sel_i` = 1 puts the main word on `prog_word_o`, and `frame_sel_i` = 0 puts the shadow word there.
- R6: One clock after it is sampled, `enh_mode_n_i` = 0 puts the stored enhancement word on `enh_word_o`, and `enh_mode_n_i` = 1 forces it to zero.
- R7: `dout_o` is 0 while `enh_mode_n_i` is 1. While it is 0, `dout_o` shows the MSB of whichever register was shifted most recently, one clock later. After reset, that is the main word.
- R8: A synchronous reset clears the main, shadow and enhancement words and all outputs. Each serial input becomes visible three system clocks after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_ld_n_i | input | 1 | Load window, active low; rising edge copies main word to shadow |
| bank_sel_i | input | 1 | 0 selects the main word as shift target, 1 the enhancement word |
| frame_sel_i | input | 1 | 1 outputs the main word, 0 the shadow word |
| enh_mode_n_i | input | 1 | Active-low enhancement mode |
| prog_word_o | output | 20 | Counter-programming word |
| enh_word_o | output | 8 | Applied enhancement bits |
| dout_o | output | 1 | Serial echo |

## Verification
The assertions check several properties on every clock. Each register holds still when no shift is qualified for it. The shadow word moves only on a load edge. The frame mux follows the main word one clock after selection. The enhancement outputs and the echo stay at zero outside enhancement mode.

Some behaviours only the bench's scenarios can show. These are the MSB-first bit ordering, which register a given select steers bits into, and the value captured at the close of a load window. The bench compares every output against a behavioural model on each clock.

// File: rtl/dbsl_pkg.sv
package dbsl_pkg;
  localparam int unsigned MAIN_W = 20;
  localparam int unsigned ENH_W  = 8;
  typedef enum logic {TGT_MAIN = 1'b0, TGT_ENH = 1'b1} target_e;
endpackage

// File: rtl/dbsl_sync_edge.sv
module dbsl_sync_edge #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [2:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= {3{RST_VAL}};
    else     st <= {st[1:0], din};
  end

  assign lvl  = st[1];
  assign rise = st[1] & ~st[2];
endmodule

// File: rtl/dbsl_shift_bank.sv
module dbsl_shift_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word_q,
  output logic         msb
);
  always_ff @(posedge clk) begin
    if (rst)           word_q <= '0;
    else if (shift_en) word_q <= {word_q[W-2:0], din};
  end

  assign msb = word_q[W-1];

  // R3 / R2: a bank without a qualified shift keeps its contents
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(word_q));
endmodule

// File: rtl/dual_bank_serial_loader.sv
module dual_bank_serial_loader
  import dbsl_pkg::*;
#(
  parameter int unsigned MAIN_BITS = MAIN_W,
  parameter int unsigned ENH_BITS  = ENH_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_clk_i,
  input  logic                 ser_dat_i,
  input  logic                 ser_ld_n_i,
  input  logic                 bank_sel_i,
  input  logic                 frame_sel_i,
  input  logic                 enh_mode_n_i,
  output logic [MAIN_BITS-1:0] prog_word_o,
  output logic [ENH_BITS-1:0]  enh_word_o,
  output logic                 dout_o
);
  logic sck_lvl, sck_rise;
  logic dat_lvl, dat_rise;
  logic ld_lvl,  ld_rise;
  logic sel_lvl, sel_rise;

  dbsl_sync_edge #(.RST_VAL(1'b0)) u_sck (.clk(clk), .rst(rst), .din(ser_clk_i),  .lvl(sck_lvl), .rise(sck_rise));
  dbsl_sync_edge #(.RST_VAL(1'b0)) u_dat (.clk(clk), .rst(rst), .din(ser_dat_i),  .lvl(dat_lvl), .rise(dat_rise));
  dbsl_sync_edge #(.RST_VAL(1'b1)) u_ld  (.clk(clk), .rst(rst), .din(ser_ld_n_i), .lvl(ld_lvl),  .rise(ld_rise));
  dbsl_sync_edge #(.RST_VAL(1'b0)) u_sel (.clk(clk), .rst(rst), .din(bank_sel_i), .lvl(sel_lvl), .rise(sel_rise));

  logic    shift_ok, sh_main, sh_enh;
  target_e last_tgt;
  logic [MAIN_BITS-1:0] main_q, shadow_q;
  logic [ENH_BITS-1:0]  enh_q;
  logic main_msb, enh_msb;

  assign shift_ok = sck_rise & ~ld_lvl;
  assign sh_main  = shift_ok & (sel_lvl == TGT_MAIN);
  assign sh_enh   = shift_ok & (sel_lvl == TGT_ENH);

  dbsl_shift_bank #(.W(MAIN_BITS)) u_main (
    .clk(clk), .rst(rst), .shift_en(sh_main), .din(dat_lvl),
    .word_q(main_q), .msb(main_msb));

  dbsl_shift_bank #(.W(ENH_BITS)) u_enh (
    .clk(clk), .rst(rst), .shift_en(sh_enh), .din(dat_lvl),
    .word_q(enh_q), .msb(enh_msb));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      last_tgt <= TGT_MAIN;
    end else begin
      if (ld_rise) shadow_q <= main_q;
      if (sh_main) last_tgt <= TGT_MAIN;
      else if (sh_enh) last_tgt <= TGT_ENH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_word_o <= '0;
      enh_word_o  <= '0;
      dout_o      <= 1'b0;
    end else begin
      prog_word_o <= frame_sel_i ? main_q : shadow_q;
      enh_word_o  <= enh_mode_n_i ? '0 : enh_q;
      dout_o      <= ~enh_mode_n_i & ((last_tgt == TGT_ENH) ? enh_msb : main_msb);
    end
  end

  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ld_rise |=> $stable(shadow_q));
  p_main_on_frame_r5: assert property (@(posedge clk) disable iff (rst)
    frame_sel_i |=> prog_word_o == $past(main_q));
  p_enh_gated_r6: assert property (@(posedge clk) disable iff (rst)
    enh_mode_n_i |=> enh_word_o == '0);
  p_dout_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    enh_mode_n_i |=> !dout_o);
  p_no_shift_in_load_r3: assert property (@(posedge clk) disable iff (rst)
    ld_lvl |=> $stable(main_q) && $stable(enh_q));

  logic unused_ok;
  assign unused_ok = sck_lvl ^ dat_rise ^ sel_rise;
endmodule

// File: tb/dual_bank_serial_loader_test.sv
module dual_bank_serial_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld_n = 1'b1, bank_sel = 1'b0;
  logic frame_sel = 1'b1, enh_mode_n = 1'b1;
  logic [19:0] prog_word;
  logic [7:0]  enh_word;
  logic        dout;

  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_serial_loader uut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_ld_n_i(ser_ld_n), .bank_sel_i(bank_sel), .frame_sel_i(frame_sel),
    .enh_mode_n_i(enh_mode_n), .prog_word_o(prog_word), .enh_word_o(enh_word),
    .dout_o(dout));

  // behavioural reference model
  bit [2:0] qc, qd, ql, qb;
  bit [19:0] m_main, m_shadow, m_prog;
  bit [7:0]  m_enh, m_enho;
  bit        m_last, m_dout;

  always @(posedge clk) begin
    if (rst) begin
      m_main = 0; m_shadow = 0; m_enh = 0; m_last = 0;
      m_prog = 0; m_enho = 0; m_dout = 0;
      qc = 3'b000; qd = 3'b000; ql = 3'b111; qb = 3'b000;
    end else begin
      bit rc, rl, sh;
      bit [19:0] old_main;
      rc = qc[1] & !qc[2];
      rl = ql[1] & !ql[2];
      sh = rc & !ql[1];
      old_main = m_main;
      m_prog  = frame_sel ? m_main : m_shadow;
      m_enho  = enh_mode_n ? 8'h00 : m_enh;
      m_dout  = !enh_mode_n && (m_last ? m_enh[7] : m_main[19]);
      if (sh) begin
        if (qb[1]) begin m_enh = {m_enh[6:0], qd[1]}; m_last = 1; end
        else       begin m_main = {m_main[18:0], qd[1]}; m_last = 0; end
      end
      if (rl) m_shadow = old_main;
      qc = {qc[1:0], ser_clk};
      qd = {qd[1:0], ser_dat};
      ql = {ql[1:0], ser_ld_n};
      qb = {qb[1:0], bank_sel};
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      compared++;
      if (prog_word !== m_prog || enh_word !== m_enho || dout !== m_dout) begin
        mismatched++;
        $display("FAIL R5/R6/R7 model compare: got %h %h %b expected %h %h %b",
                 prog_word, enh_word, dout, m_prog, m_enho, m_dout);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;   wait_clks(GAP);
    ser_clk = 1'b1; wait_clks(GAP);
    ser_clk = 1'b0; wait_clks(GAP);
  endtask

  task automatic send_word(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait_clks(3);
    check("R8 reset prog", {12'h0, prog_word}, 32'h0);
    check("R8 reset enh", {24'h0, enh_word}, 32'h0);
    check("R8 reset dout", {31'h0, dout}, 32'h0);
    rst = 1'b0;
    wait_clks(2);

    // R1: main word, MSB first
    ser_ld_n = 1'b0; wait_clks(GAP);
    send_word(32'hA5C3E, 20);
    wait_clks(2);
    check("R1 main word", {12'h0, prog_word}, 32'hA5C3E);
    enh_mode_n = 1'b0; wait_clks(2);
    check("R7 echo main msb", {31'h0, dout}, 32'h1);
    ser_ld_n = 1'b1; wait_clks(6);

    // R4: shadow captured on load edge
    frame_sel = 1'b0; wait_clks(2);
    check("R4 shadow load", {12'h0, prog_word}, 32'hA5C3E);

    // R2: enhancement target
    bank_sel = 1'b1; ser_ld_n = 1'b0; wait_clks(GAP);
    send_word(32'h5A, 8);
    wait_clks(2);
    check("R6 enh applied", {24'h0, enh_word}, 32'h5A);
    check("R7 echo enh msb", {31'h0, dout}, 32'h0);
    frame_sel = 1'b1; wait_clks(2);
    check("R2 main untouched", {12'h0, prog_word}, 32'hA5C3E);
    enh_mode_n = 1'b1; wait_clks(2);
    check("R6 enh forced zero", {24'h0, enh_word}, 32'h0);
    check("R7 echo off", {31'h0, dout}, 32'h0);
    ser_ld_n = 1'b1; bank_sel = 1'b0; wait_clks(6);

    // R3: edges outside load window ignored
    send_word(32'hFF, 8);
    wait_clks(2);
    check("R3 main ignored", {12'h0, prog_word}, 32'hA5C3E);
    enh_mode_n = 1'b0; wait_clks(2);
    check("R3 enh ignored", {24'h0, enh_word}, 32'h5A);

    // R5: staged word versus shadow
    ser_ld_n = 1'b0; wait_clks(GAP);
    send_word(32'h12345, 20);
    wait_clks(2);
    check("R5 frame main", {12'h0, prog_word}, 32'h12345);
    check("R7 echo after main shift", {31'h0, dout}, 32'h0);
    frame_sel = 1'b0; wait_clks(2);
    check("R5 frame shadow", {12'h0, prog_word}, 32'hA5C3E);
    ser_ld_n = 1'b1; wait_clks(6);
    check("R4 second load", {12'h0, prog_word}, 32'h12345);

    wait_clks(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule